// File: doc/BRIEF.md
# Queue-Setup Mailbox Request Engine

This block sits on the requesting side of a 256-bit shared mailbox. Both sides reach the mailbox through a simple register port of eight 32-bit words. The engine accepts one of two commands. A setup command carries four 64-bit physical base addresses (event, completion, receive and send queues), a 32-bit interrupt vector argument and a reset request flag. A teardown command carries only the reset flag.

For a setup, the engine checks its arguments and first waits until the mailbox belongs to it. It then writes eight packed words in ascending order. The write to the last word hands the mailbox to the other side. The engine then polls that last word until ownership returns, and judges the response header. A teardown follows the same steps but writes only the header word.

Each command ends with a one-cycle done pulse and a 2-bit result code: 0 for ok, 1 for invalid argument, 2 for timeout and 3 for protocol error.

Top module: `mbox_req_engine`

## Requirements
- R1: A setup whose queue addresses are not all 4 KiB aligned (any of bits [11:0] set), or whose vector argument has any bit above bit 15 set, finishes with result 1 and makes no bus read or write.
- R2: For a setup, the frame number of each address is address bit [63:12]. Words 0..5, read as one little-endian 192-bit field, hold the low 48 bits of the frame numbers, one after another in the order event, completion, receive, send. Word 6 bits [15:0] hold the top 4 frame bits of each queue: event in [3:0], completion in [7:4], receive in [11:8] and send in [15:12]. Word 6 bits [31:16] hold vector bits [15:0].
- R3: The setup header in word 7 has type 1 in bits [2:0], version 0 in bits [5:3], direction 0 in bit 7, the reset flag in bit 24, and every other bit 0.
- R4: Before any write, the engine reads word 7 until bit 31 reads 0. It then writes word 0 through word 7 in ascending order, one handshake each. A request holds its address until it is acknowledged, and a read and a write are never requested together.
- R5: A teardown makes exactly one write, to word 7. The value has type 2 in bits [2:0], version 0, direction 0 and the reset flag in bit 24.
- R6: After the hand-off the engine reads word 7 at most 20000 times. If bit 31 is still 1 on the last of these reads, the result is 2. The same limit applies to the ownership wait before writing.
- R7: Between two reads of one poll loop, the read request stays low for exactly `poll_delay` cycles.
- R8: If the reset flag was requested and word 7 reads 0xFFFFFFFF after the hand-off, the result is 0.
- R9: Once bit 31 returns to 0 after the hand-off, the result is 0 only if all of the following hold: bits [2:0] equal the request type, bits [5:3] are at most 0, bit 7 is 1 and bits [15:8] are 0. Any other response gives result 3.
- R10: `done` is high for exactly one cycle per command, with `result` valid in that cycle. A command presented while another command is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Start a command (taken only when idle) |
| cmd_teardown | input | 1 | 1 = teardown, 0 = setup |
| cmd_reset | input | 1 | Reset request flag sent in the header |
| evq_addr | input | 64 | Event queue base address |
| cmpq_addr | input | 64 | Completion queue base address |
| rcvq_addr | input | 64 | Receive queue base address |
| sndq_addr | input | 64 | Send queue base address |
| vec_idx | input | 32 | Interrupt vector argument |
| poll_delay | input | 16 | Idle cycles between poll reads |
| bus_wr_en | output | 1 | Write request to mailbox |
| bus_rd_en | output | 1 | Read request to mailbox |
| bus_addr | output | 3 | Mailbox word index |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Request acknowledge |
| bus_rdata | input | 32 | Read data, valid with acknowledge |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 invalid, 2 timeout, 3 protocol error |

## Verification
The hardest conditions to reach are the exhausted poll limit and a second command that arrives mid-flight. Both depend on how the mailbox model on the other side of the port behaves, not on the engine's inputs. The bench model can hold word 7 busy for a programmed number of reads, or indefinitely. This lets it force the full 20000-read timeout, prolong a setup while a stray teardown is pulsed, and release ownership late in the pre-write wait. Random rounds combine random frame numbers, including the top nibbles, with random response headers so that every acceptance rule is exercised.

// File: rtl/mbox_pkg.sv
// Package: shared types and constants for the mailbox request engine.
// Assumes an eight-word, 32-bit mailbox whose last word carries the header.
package mbox_pkg;

    localparam int NUM_WORDS = 8;
    localparam int WORD_W    = 32;
    localparam int WIDX_W    = $clog2(NUM_WORDS);
    localparam logic [WIDX_W-1:0] HDR_WORD = WIDX_W'(NUM_WORDS - 1);

    localparam logic [2:0] KIND_SETUP = 3'd1;
    localparam logic [2:0] KIND_TEAR  = 3'd2;
    localparam logic [2:0] REQ_VER    = 3'd0;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_INVAL   = 2'd1,
        RES_TIMEOUT = 2'd2,
        RES_PROTO   = 2'd3
    } res_e;

    // Header word layout, most significant field first.
    typedef struct packed {
        logic       owner;
        logic [5:0] rsv_hi;
        logic       reset_req;
        logic [7:0] rsv_mid;
        logic [7:0] status;
        logic       dir;
        logic       rsv_lo;
        logic [2:0] ver;
        logic [2:0] kind;
    } hdr_t;

endpackage

// File: rtl/mbox_packer.sv
// Module: mbox_packer
// Validates setup arguments and builds the eight mailbox words from them.
// Assumes 4 * frame low width + 4 * frame high width + vector width + 32
// equals 256 bits, as the default parameters give.
module mbox_packer
    import mbox_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int PAGE_SHIFT = 12,
    parameter int PFN_LO_W   = 48,
    parameter int VEC_W      = 16,
    parameter int IDX_W      = 32,
    parameter int NQ         = 4
) (
    input  logic [NQ-1:0][ADDR_W-1:0]        q_addr,
    input  logic [IDX_W-1:0]                 vec,
    input  logic                             reset_req,
    input  logic                             teardown,
    output logic                             args_ok,
    output logic [NUM_WORDS-1:0][WORD_W-1:0] words
);

    localparam int PFN_W    = ADDR_W - PAGE_SHIFT;
    localparam int PFN_HI_W = PFN_W - PFN_LO_W;
    localparam int HI_BASE  = NQ * PFN_LO_W;
    localparam int VEC_BASE = HI_BASE + NQ * PFN_HI_W;
    localparam int FLAT_W   = NUM_WORDS * WORD_W;
    localparam int HDR_BASE = FLAT_W - WORD_W;

    logic [NQ-1:0]     aligned;
    logic [FLAT_W-1:0] flat;
    hdr_t              hdr;

    // Per-queue alignment test.
    generate
        for (genvar q = 0; q < NQ; q++) begin : g_align
            assign aligned[q] = (q_addr[q][PAGE_SHIFT-1:0] == '0);
        end
    endgenerate

    // Arguments pass when all queues are aligned and the vector fits.
    assign args_ok = (&aligned) && (vec[IDX_W-1:VEC_W] == '0);

    // Build the request header from the command kind and reset flag.
    always_comb begin
        hdr           = '0;
        hdr.kind      = teardown ? KIND_TEAR : KIND_SETUP;
        hdr.ver       = REQ_VER;
        hdr.dir       = 1'b0;
        hdr.reset_req = reset_req;
    end

    // Pack frame-number fields, vector and header into one flat image.
    always_comb begin
        flat = '0;
        for (int q = 0; q < NQ; q++) begin
            flat[q*PFN_LO_W +: PFN_LO_W] =
                q_addr[q][PAGE_SHIFT +: PFN_LO_W];
            flat[HI_BASE + q*PFN_HI_W +: PFN_HI_W] =
                q_addr[q][PAGE_SHIFT + PFN_LO_W +: PFN_HI_W];
        end
        flat[VEC_BASE +: VEC_W]   = vec[VEC_W-1:0];
        flat[HDR_BASE +: WORD_W]  = hdr;
    end

    // Slice the flat image into little-endian mailbox words.
    generate
        for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
            assign words[k] = flat[k*WORD_W +: WORD_W];
        end
    endgenerate

endmodule

// File: rtl/mbox_resp_check.sv
// Module: mbox_resp_check
// Classifies a word read back from the mailbox header position.
// Assumes the word is sampled with the bus acknowledge.
module mbox_resp_check
    import mbox_pkg::*;
(
    input  logic [WORD_W-1:0] rd_word,
    input  logic [2:0]        exp_kind,
    input  logic [2:0]        exp_ver,
    input  logic              reset_req,
    output logic              owned,
    output logic              reset_skip,
    output logic              resp_good
);

    hdr_t h;

    assign h = rd_word;

    // Ownership has returned when the owner bit reads clear.
    assign owned = ~h.owner;

    // All-ones read is an accepted outcome only when a reset was requested.
    assign reset_skip = reset_req && (&rd_word);

    // Protocol and status acceptance rule for a returned header.
    always_comb begin
        resp_good = (h.kind == exp_kind) && (h.ver <= exp_ver) &&
                    h.dir && (h.status == 8'd0);
    end

endmodule

// File: rtl/mbox_seq.sv
// Module: mbox_seq
// Command sequencer: argument gate, ownership wait, ordered word writes,
// bounded response polling and result reporting.
// Assumes the bus holds acknowledge for one cycle per accepted request.
module mbox_seq
    import mbox_pkg::*;
#(
    parameter int MAX_POLLS = 20000,
    parameter int DLY_W     = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cmd_valid,
    input  logic                             cmd_teardown,
    input  logic                             args_ok,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0] words,
    input  logic                             owned,
    input  logic                             reset_skip,
    input  logic                             resp_good,
    input  logic [DLY_W-1:0]                 poll_delay,
    input  logic                             bus_ack,
    output logic                             accept,
    output logic                             bus_wr_en,
    output logic                             bus_rd_en,
    output logic [WIDX_W-1:0]                bus_addr,
    output logic [WORD_W-1:0]                bus_wdata,
    output logic                             done,
    output logic [1:0]                       result
);

    localparam int TRY_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
    localparam logic [TRY_W-1:0] LAST_TRY = TRY_W'(MAX_POLLS - 1);

    typedef enum logic [2:0] {
        S_IDLE, S_CHECK, S_RD, S_WAIT, S_WRITE
    } st_e;

    st_e               state;
    logic              post;
    logic              tear;
    logic [WIDX_W-1:0] idx;
    logic [TRY_W-1:0]  tries;
    logic [DLY_W-1:0]  dly;
    res_e              res_q;

    assign accept    = (state == S_IDLE) && cmd_valid;
    assign bus_rd_en = (state == S_RD);
    assign bus_wr_en = (state == S_WRITE);
    assign bus_addr  = (state == S_RD) ? HDR_WORD : idx;
    assign bus_wdata = words[idx];
    assign result    = res_q;

    // Main command state machine with retry and delay counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            post  <= 1'b0;
            tear  <= 1'b0;
            idx   <= '0;
            tries <= '0;
            dly   <= '0;
            done  <= 1'b0;
            res_q <= RES_OK;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (cmd_valid) begin
                        tear  <= cmd_teardown;
                        state <= S_CHECK;
                    end
                end
                S_CHECK: begin
                    if (tear || args_ok) begin
                        post  <= 1'b0;
                        tries <= '0;
                        state <= S_RD;
                    end else begin
                        res_q <= RES_INVAL;
                        done  <= 1'b1;
                        state <= S_IDLE;
                    end
                end
                S_RD: begin
                    if (bus_ack) begin
                        if (post && reset_skip) begin
                            res_q <= RES_OK;
                            done  <= 1'b1;
                            state <= S_IDLE;
                        end else if (owned) begin
                            if (!post) begin
                                idx   <= tear ? HDR_WORD : '0;
                                state <= S_WRITE;
                            end else begin
                                res_q <= resp_good ? RES_OK : RES_PROTO;
                                done  <= 1'b1;
                                state <= S_IDLE;
                            end
                        end else if (tries == LAST_TRY) begin
                            res_q <= RES_TIMEOUT;
                            done  <= 1'b1;
                            state <= S_IDLE;
                        end else begin
                            tries <= tries + 1'b1;
                            if (poll_delay != '0) begin
                                dly   <= poll_delay - 1'b1;
                                state <= S_WAIT;
                            end
                        end
                    end
                end
                S_WAIT: begin
                    if (dly == '0) state <= S_RD;
                    else           dly   <= dly - 1'b1;
                end
                S_WRITE: begin
                    if (bus_ack) begin
                        if (idx == HDR_WORD) begin
                            post  <= 1'b1;
                            tries <= '0;
                            state <= S_RD;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R4: read and write are never requested together.
    p_rw_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_en && bus_rd_en));

    // R4: an unacknowledged read keeps its request and address.
    p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && !bus_ack) |=> (bus_rd_en && $stable(bus_addr)));

    // R4: after a non-final word write, the next word is written.
    p_wr_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_ack && bus_addr != HDR_WORD) |=>
        (bus_wr_en && bus_addr == $past(bus_addr) + 1'b1));

    // R6: the retry counter never passes the last allowed attempt.
    p_try_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tries <= LAST_TRY);

    // R10: done lasts one cycle.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/mbox_req_engine.sv
// Module: mbox_req_engine (top)
// Captures a command, then drives the mailbox request protocol through the
// packer, response checker and sequencer.
// Assumes a register-port bus with a one-cycle acknowledge per request.
module mbox_req_engine
    import mbox_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int PAGE_SHIFT = 12,
    parameter int PFN_LO_W   = 48,
    parameter int VEC_W      = 16,
    parameter int IDX_W      = 32,
    parameter int MAX_POLLS  = 20000,
    parameter int DLY_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_teardown,
    input  logic              cmd_reset,
    input  logic [ADDR_W-1:0] evq_addr,
    input  logic [ADDR_W-1:0] cmpq_addr,
    input  logic [ADDR_W-1:0] rcvq_addr,
    input  logic [ADDR_W-1:0] sndq_addr,
    input  logic [IDX_W-1:0]  vec_idx,
    input  logic [DLY_W-1:0]  poll_delay,
    output logic              bus_wr_en,
    output logic              bus_rd_en,
    output logic [2:0]        bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic              bus_ack,
    input  logic [31:0]       bus_rdata,
    output logic              done,
    output logic [1:0]        result
);

    localparam int NQ = 4;

    logic [NQ-1:0][ADDR_W-1:0]        cap_addr;
    logic [IDX_W-1:0]                 cap_vec;
    logic                             cap_rst;
    logic                             cap_tear;
    logic                             accept;
    logic                             args_ok;
    logic [NUM_WORDS-1:0][WORD_W-1:0] words;
    logic                             owned;
    logic                             reset_skip;
    logic                             resp_good;

    // Hold command arguments for the life of the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_vec  <= '0;
            cap_rst  <= 1'b0;
            cap_tear <= 1'b0;
        end else if (accept) begin
            cap_addr <= {sndq_addr, rcvq_addr, cmpq_addr, evq_addr};
            cap_vec  <= vec_idx;
            cap_rst  <= cmd_reset;
            cap_tear <= cmd_teardown;
        end
    end

    mbox_packer #(
        .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .PFN_LO_W(PFN_LO_W),
        .VEC_W(VEC_W), .IDX_W(IDX_W), .NQ(NQ)
    ) u_packer (
        .q_addr    (cap_addr),
        .vec       (cap_vec),
        .reset_req (cap_rst),
        .teardown  (cap_tear),
        .args_ok   (args_ok),
        .words     (words)
    );

    mbox_resp_check u_resp (
        .rd_word    (bus_rdata),
        .exp_kind   (cap_tear ? KIND_TEAR : KIND_SETUP),
        .exp_ver    (REQ_VER),
        .reset_req  (cap_rst),
        .owned      (owned),
        .reset_skip (reset_skip),
        .resp_good  (resp_good)
    );

    mbox_seq #(.MAX_POLLS(MAX_POLLS), .DLY_W(DLY_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_teardown (cmd_teardown),
        .args_ok      (args_ok),
        .words        (words),
        .owned        (owned),
        .reset_skip   (reset_skip),
        .resp_good    (resp_good),
        .poll_delay   (poll_delay),
        .bus_ack      (bus_ack),
        .accept       (accept),
        .bus_wr_en    (bus_wr_en),
        .bus_rd_en    (bus_rd_en),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .done         (done),
        .result       (result)
    );

    // R5: a teardown only ever writes the header word.
    p_tear_hdr_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && cap_tear) |-> (bus_addr == HDR_WORD));

    // R1: an invalid-argument finish follows a cycle with no bus request.
    p_inval_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en || bus_rd_en) |=> !(done && result == RES_INVAL));

endmodule

// File: tb/mbox_req_engine_bench.sv
module mbox_req_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_teardown = 1'b0;
    logic        cmd_reset = 1'b0;
    logic [63:0] evq_addr = '0, cmpq_addr = '0, rcvq_addr = '0, sndq_addr = '0;
    logic [31:0] vec_idx = '0;
    logic [15:0] poll_delay = '0;
    logic        bus_wr_en, bus_rd_en;
    logic [2:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata;
    logic        done;
    logic [1:0]  result;

    int total = 0;
    int fails = 0;

    // Mailbox model state.
    logic [31:0] mem [8];
    logic [31:0] resp_word = '0;
    int unsigned busy_left = 0;
    int unsigned resp_busy = 0;
    int          wr_n = 0, rd_n = 0, done_n = 0, gap = 0, last_gap = -1;
    bit          in_gap = 0;
    logic [2:0]  wr_a [16];
    logic [31:0] wr_d [16];

    // Current command for expected-value functions.
    logic [63:0] cur_a [4];
    logic [31:0] cur_vec;
    bit          cur_rst, cur_tear;

    always #10 clk = ~clk;

    mbox_req_engine u_mbox_req_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .cmd_teardown(cmd_teardown), .cmd_reset(cmd_reset),
        .evq_addr(evq_addr), .cmpq_addr(cmpq_addr), .rcvq_addr(rcvq_addr),
        .sndq_addr(sndq_addr), .vec_idx(vec_idx), .poll_delay(poll_delay),
        .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .done(done), .result(result)
    );

    assign bus_rdata = (bus_addr == 3'd7 && busy_left != 0) ? 32'h8000_0000
                                                            : mem[bus_addr];

    // Mailbox model: acknowledge, storage, ownership and gap measurement.
    always @(posedge clk) begin
        bus_ack <= (bus_wr_en || bus_rd_en) && !bus_ack;
        if (done) done_n <= done_n + 1;
        if (bus_wr_en) in_gap <= 0;
        if (bus_wr_en && bus_ack) begin
            if (wr_n < 16) begin
                wr_a[wr_n] <= bus_addr;
                wr_d[wr_n] <= bus_wdata;
            end
            wr_n <= wr_n + 1;
            mem[bus_addr] <= bus_wdata;
            if (bus_addr == 3'd7) begin
                mem[7]    <= resp_word;
                busy_left <= resp_busy;
            end
        end
        if (bus_rd_en && bus_ack) begin
            rd_n   <= rd_n + 1;
            in_gap <= 1;
            gap    <= 0;
            if (bus_addr == 3'd7 && busy_left != 0) busy_left <= busy_left - 1;
        end else if (in_gap && !bus_rd_en) begin
            gap <= gap + 1;
        end else if (in_gap && bus_rd_en) begin
            last_gap <= gap;
            in_gap   <= 0;
        end
    end

    task automatic chk(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rsp(input logic [2:0] kind,
        input logic [2:0] ver, input bit dir, input logic [7:0] st);
        return {16'h0, st, dir, 1'b0, ver, kind};
    endfunction

    // Expected mailbox word k from the requirement layout.
    function automatic logic [31:0] exp_word(input int k);
        logic [255:0] f;
        f = '0;
        for (int q = 0; q < 4; q++) begin
            f[48*q +: 48]     = cur_a[q][59:12];
            f[192 + 4*q +: 4] = cur_a[q][63:60];
        end
        f[208 +: 16] = cur_vec[15:0];
        f[224 +: 32] = {7'h0, cur_rst, 21'h0, (cur_tear ? 3'd2 : 3'd1)};
        return f[32*k +: 32];
    endfunction

    // Run one command; pre_busy = reads before ownership at start.
    task automatic run_cmd(input bit tear, input bit rst,
        input logic [63:0] a0, a1, a2, a3, input logic [31:0] vec,
        input logic [15:0] dly, input int unsigned pre_busy,
        input logic [31:0] rword, input int unsigned rbusy,
        output logic [1:0] res);
        @(negedge clk);
        cur_a[0] = a0; cur_a[1] = a1; cur_a[2] = a2; cur_a[3] = a3;
        cur_vec = vec; cur_rst = rst; cur_tear = tear;
        mem[7] = 32'h0; busy_left = pre_busy;
        resp_word = rword; resp_busy = rbusy;
        wr_n = 0; rd_n = 0; last_gap = -1;
        evq_addr = a0; cmpq_addr = a1; rcvq_addr = a2; sndq_addr = a3;
        vec_idx = vec; cmd_teardown = tear; cmd_reset = rst; poll_delay = dly;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (done !== 1'b1) @(negedge clk);
        res = result;
        @(negedge clk);
        chk("R10 done single cycle", done, 0);
    endtask

    task automatic chk_setup_words(input string tag);
        chk({tag, " write count"}, wr_n, 8);
        for (int k = 0; k < 8; k++) begin
            chk({tag, " write order"}, wr_a[k], k);
            chk({tag, " word data"}, wr_d[k], exp_word(k));
        end
    endtask

    initial begin
        logic [1:0] r;
        int seed;
        seed = $urandom(32'd2024);
        for (int k = 0; k < 8; k++) mem[k] = '0;
        repeat (3) @(negedge clk);
        chk("R10 reset done low", done, 0);
        chk("R4 reset no request", {bus_wr_en, bus_rd_en}, 0);
        rst_n = 1'b1;

        // Directed setup, nonzero top nibbles, busy response twice, delay 2.
        run_cmd(0, 0, 64'hA123_4567_89AB_C000, 64'h5FED_CBA9_8765_4000,
                64'h3000_0000_0001_0000, 64'hF111_2222_3333_4000,
                32'h0000_BEEF, 16'd2, 0, rsp(3'd1, 3'd0, 1, 8'd0), 2, r);
        chk("R9 good setup response", r, 0);
        chk_setup_words("R2 R3 directed");
        chk("R6 read count", rd_n, 4);
        chk("R7 poll gap", last_gap, 2);

        // Ownership held by the peer for three reads before writing.
        run_cmd(0, 1, 64'h1000, 64'h2000, 64'h3000, 64'h4000, 32'h1,
                16'd0, 3, rsp(3'd1, 3'd0, 1, 8'd0), 0, r);
        chk("R4 late ownership result", r, 0);
        chk("R4 pre-write reads", rd_n, 5);
        chk_setup_words("R4 late ownership");

        // Misaligned address and oversized vector.
        run_cmd(0, 0, 64'h1000, 64'h2000, 64'h3800, 64'h4000, 32'h5,
                16'd0, 0, 0, 0, r);
        chk("R1 misaligned result", r, 1);
        chk("R1 misaligned no bus", wr_n + rd_n, 0);
        run_cmd(0, 0, 64'h1000, 64'h2000, 64'h3000, 64'h4000, 32'h0001_0000,
                16'd0, 0, 0, 0, r);
        chk("R1 vector result", r, 1);
        chk("R1 vector no bus", wr_n + rd_n, 0);

        // Teardown with reset flag.
        run_cmd(1, 1, 64'h123, 0, 0, 0, 32'hFFFF_FFFF, 16'd1, 0,
                rsp(3'd2, 3'd0, 1, 8'd0), 1, r);
        chk("R5 teardown result", r, 0);
        chk("R5 teardown write count", wr_n, 1);
        chk("R5 teardown addr", wr_a[0], 7);
        chk("R5 teardown data", wr_d[0], 32'h0100_0002);

        // Rejected responses.
        run_cmd(1, 0, 0, 0, 0, 0, 0, 16'd0, 0, rsp(3'd1, 3'd0, 1, 8'd0), 0, r);
        chk("R9 wrong type", r, 3);
        run_cmd(1, 0, 0, 0, 0, 0, 0, 16'd0, 0, rsp(3'd2, 3'd1, 1, 8'd0), 0, r);
        chk("R9 newer version", r, 3);
        run_cmd(1, 0, 0, 0, 0, 0, 0, 16'd0, 0, rsp(3'd2, 3'd0, 0, 8'd0), 0, r);
        chk("R9 direction zero", r, 3);
        run_cmd(1, 0, 0, 0, 0, 0, 0, 16'd0, 0, rsp(3'd2, 3'd0, 1, 8'd5), 0, r);
        chk("R9 nonzero status", r, 3);

        // All-ones read back with reset requested.
        run_cmd(0, 1, 64'h7000, 64'h8000, 64'h9000, 64'hA000, 32'h0,
                16'd0, 0, 32'hFFFF_FFFF, 0, r);
        chk("R8 all-ones accepted", r, 0);

        // Second command during a busy setup is ignored.
        fork
            run_cmd(0, 0, 64'h1000, 64'h2000, 64'h3000, 64'h4000, 32'h9,
                    16'd5, 0, rsp(3'd1, 3'd0, 1, 8'd0), 10, r);
            begin
                repeat (30) @(negedge clk);
                cmd_teardown = 1'b1;
                cmd_valid = 1'b1;
                @(negedge clk);
                cmd_valid = 1'b0;
            end
        join
        begin
            int d0;
            d0 = done_n;
            repeat (30) @(negedge clk);
            chk("R10 busy command ignored done", done_n, d0);
        end
        chk("R10 busy command result", r, 0);
        chk("R10 busy command writes", wr_n, 8);
        chk("R7 gap five", last_gap, 5);

        // Random rounds.
        for (int i = 0; i < 16; i++) begin
            logic [63:0] a [4];
            logic [31:0] w;
            bit tear, rst;
            logic [1:0] er;
            int sel;
            for (int q = 0; q < 4; q++)
                a[q] = {$urandom, $urandom} & ~64'hFFF;
            tear = ($urandom % 4) == 0;
            rst  = $urandom % 2;
            sel  = $urandom % 4;
            case (sel)
                0: w = rsp(tear ? 3'd2 : 3'd1, 3'd0, 1, 8'd0);
                1: w = rsp(tear ? 3'd2 : 3'd1, 3'($urandom % 7 + 1), 1, 8'd0);
                2: w = rsp(tear ? 3'd2 : 3'd1, 3'd0, 1, 8'($urandom % 255 + 1));
                default: w = rsp(3'($urandom), 3'd0, $urandom % 2, 8'd0);
            endcase
            if (w[2:0] == (tear ? 3'd2 : 3'd1) && w[5:3] == 0 && w[7] &&
                w[15:8] == 0) er = 0;
            else er = 3;
            run_cmd(tear, rst, a[0], a[1], a[2], a[3], $urandom % 65536,
                    16'($urandom % 4), $urandom % 3, w, $urandom % 4, r);
            chk("R9 random result", r, er);
            if (tear) begin
                chk("R5 random teardown writes", wr_n, 1);
                chk("R5 random teardown data", wr_d[0], exp_word(7));
            end else begin
                chk_setup_words("R2 R3 random");
            end
        end

        // Full-length timeout after hand-off.
        run_cmd(1, 0, 0, 0, 0, 0, 0, 16'd0, 0, rsp(3'd2, 3'd0, 1, 8'd0),
                32'hFFFF_FFFF, r);
        chk("R6 timeout result", r, 2);
        chk("R6 timeout read count", rd_n, 20001);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule